// File: doc/BRIEF.md
# Keyed Tone Identity Transmitter

The block repeatedly sends a fixed identity word as a keyed tone on a single output line. A receiver can then check which design sits inside a device without touching it. A bit timer divides the fast clock down to the bit rate, for example 200 fast-clock cycles per bit at 200 MHz, which gives 1 Mbit/s. A sequencer walks the identity word starting at its most significant bit. A counter-based tone generator stands in for a delay-chain oscillator. It toggles the output after a number of fast-clock cycles equal to a base delay plus a stage count.

The two keying modes are picked with `mode_i`:
- **Two-tone mode.** A 0 bit uses the short loop, which gives a higher tone. A 1 bit uses the long loop, which gives a lower tone.
- **On-off mode.** A 1 bit sends the short-loop carrier. A 0 bit leaves the line silent for the whole bit.

Transmission runs for as long as `en_i` is high. It can also be started once by an internal event: a qualified code on the trigger input that matches a parameter value. That event sends exactly one complete repetition of the word. When the block is idle, the tone line is held low so that nothing toggles.

Top module: `id_tone_tx`

## Requirements
- R1: While `rst_ni` is low, `tone_o`, `bit_o` and `frame_o` are all 0.
- R2: In any cycle where the block is inactive (`en_i` low and no triggered frame in progress), `bit_o` and `frame_o` are 0 in that cycle. From the following cycle on, `tone_o` is 0 and stays 0 until the block is active again.
- R3: Bits are sent most significant first, starting with `ID_WORD[ID_W-1]`. Each bit is shown on `bit_o` for exactly `BIT_DIV` cycles, and `bit_o` changes only at a bit boundary.
- R4: While active, the word repeats with no gap: bit 0 is followed directly by `ID_WORD[ID_W-1]`. `frame_o` is a one-cycle pulse in the first cycle of each repetition.
- R5: In two-tone mode (`mode_i`=0), a 0 bit toggles `tone_o` every `BASE+N_STG` cycles. A 1 bit toggles it every `BASE+N_STG+K_STG` cycles.
- R6: In on-off mode (`mode_i`=1), a 1 bit toggles `tone_o` every `BASE+N_STG` cycles. A 0 bit keeps `tone_o` at 0 for the whole bit.
- R7: Every bit starts with a restarted tone. `tone_o` is 0 in the first cycle of each bit, and its first toggle comes one half period later.
- R8: Dropping `en_i` returns the sequencer to the first bit. The next active cycle raises `frame_o` and shows `ID_WORD[ID_W-1]`.
- R9: While the block is inactive, a cycle with `trig_vld_i`=1 and `trig_data_i`=`TRIG_CODE` starts activity on the next cycle. Exactly one full repetition of the word is sent, and then the block goes idle again.
- R10: A trigger whose code differs from `TRIG_CODE` has no effect, and all outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock that drives the tone counter and the bit timer |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Keeps transmission running while high |
| mode_i | input | 1 | Keying mode: 0 is two-tone, 1 is on-off; hold it stable while active |
| trig_vld_i | input | 1 | Qualifies `trig_data_i` for event matching |
| trig_data_i | input | TRIG_W | Event code compared against `TRIG_CODE` |
| tone_o | output | 1 | Keyed tone line; idle level is 0 |
| bit_o | output | 1 | Identity bit currently being keyed |
| frame_o | output | 1 | Pulse in the first cycle of each repetition of the word |

## Verification
`bit_o` and `frame_o` are combinational from the bit state, so they react in the same cycle that `en_i` changes. A trigger match only becomes visible one cycle later, when the registered frame flag has set. `tone_o` is registered: its value in a cycle comes from the counter state at the previous edge, so it falls to idle exactly one cycle after the block goes inactive. The bench drives inputs just after each rising edge and pushes the expected outputs for that same cycle. It models the registers explicitly: the bit position, the cycle within the bit and the tone level. The monitor compares at the following falling edge, so every check lines up with the cycle in which the design commits the value.

// File: rtl/id_tone_pkg.sv
package id_tone_pkg;
  typedef enum logic {
    KEY_TWO_TONE = 1'b0,
    KEY_ON_OFF   = 1'b1
  } key_mode_e;
endpackage

// File: rtl/id_bit_timer.sv
module id_bit_timer #(
  parameter int BIT_DIV = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic strobe_o,
  output logic first_o
);
  localparam int CNT_W = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign strobe_o = run_i && (cnt_q == LAST);
  assign first_o  = (cnt_q == '0);
endmodule

// File: rtl/id_bit_seq.sv
module id_bit_seq #(
  parameter int          ID_W    = 64,
  parameter logic [63:0] ID_WORD = 64'hA5C3_0F96_1E2D_7B48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic step_i,
  output logic bit_o,
  output logic head_o,
  output logic last_o
);
  localparam int PTR_W = (ID_W > 1) ? $clog2(ID_W) : 1;
  localparam logic [PTR_W-1:0] TOP = PTR_W'(ID_W - 1);
  localparam logic [ID_W-1:0]  WORD = ID_WORD[ID_W-1:0];

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_q <= '0;
    else if (!run_i)      ptr_q <= '0;
    else if (step_i)      ptr_q <= (ptr_q == TOP) ? '0 : ptr_q + 1'b1;
  end

  // pointer counts up, word is indexed MSB first
  assign idx    = TOP - ptr_q;
  assign bit_o  = WORD[idx];
  assign head_o = (ptr_q == '0);
  assign last_o = (ptr_q == TOP);
endmodule

// File: rtl/id_tone_gen.sv
module id_tone_gen #(
  parameter int BASE  = 3,
  parameter int N_STG = 2,
  parameter int K_STG = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic bit_i,
  input  logic on_off_i,
  output logic tone_o
);
  localparam int HP_S = BASE + N_STG;
  localparam int HP_L = BASE + N_STG + K_STG;
  localparam int TC_W = $clog2(HP_L + 1);

  logic [TC_W-1:0] tcnt_q;
  logic [TC_W-1:0] half_last;
  logic            tone_q;
  logic            key_on;

  always_comb begin
    key_on    = !on_off_i || bit_i;
    half_last = (!on_off_i && bit_i) ? TC_W'(HP_L - 1) : TC_W'(HP_S - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q <= '0;
      tone_q <= 1'b0;
    end else if (!run_i || restart_i || !key_on) begin
      tcnt_q <= '0;
      tone_q <= 1'b0;
    end else if (tcnt_q == half_last) begin
      tcnt_q <= '0;
      tone_q <= ~tone_q;
    end else begin
      tcnt_q <= tcnt_q + 1'b1;
    end
  end

  assign tone_o = tone_q;
endmodule

// File: rtl/id_tone_tx.sv
module id_tone_tx
  import id_tone_pkg::*;
#(
  parameter int          ID_W      = 64,
  parameter logic [63:0] ID_WORD   = 64'hA5C3_0F96_1E2D_7B48,
  parameter int          BIT_DIV   = 200,
  parameter int          BASE      = 3,
  parameter int          N_STG     = 2,
  parameter int          K_STG     = 5,
  parameter int          TRIG_W    = 8,
  parameter logic [7:0]  TRIG_CODE = 8'h5C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic              trig_vld_i,
  input  logic [TRIG_W-1:0] trig_data_i,
  output logic              tone_o,
  output logic              bit_o,
  output logic              frame_o
);
  localparam logic [TRIG_W-1:0] CODE = TRIG_W'(TRIG_CODE);

  key_mode_e mode;
  logic      burst_q;
  logic      active;
  logic      trig_hit;
  logic      bit_stb;
  logic      bit_first;
  logic      cur_bit;
  logic      at_head;
  logic      at_last;

  assign mode     = key_mode_e'(mode_i);
  assign active   = en_i || burst_q;
  assign trig_hit = trig_vld_i && (trig_data_i == CODE);

  // one-shot frame started by an internal event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     burst_q <= 1'b0;
    else if (!active && trig_hit)    burst_q <= 1'b1;
    else if (bit_stb && at_last)     burst_q <= 1'b0;
  end

  id_bit_timer #(.BIT_DIV(BIT_DIV)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (active),
    .strobe_o(bit_stb),
    .first_o (bit_first)
  );

  id_bit_seq #(.ID_W(ID_W), .ID_WORD(ID_WORD)) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (active),
    .step_i(bit_stb),
    .bit_o (cur_bit),
    .head_o(at_head),
    .last_o(at_last)
  );

  id_tone_gen #(.BASE(BASE), .N_STG(N_STG), .K_STG(K_STG)) u_tone (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (active),
    .restart_i(bit_stb),
    .bit_i    (cur_bit),
    .on_off_i (mode == KEY_ON_OFF),
    .tone_o   (tone_o)
  );

  assign bit_o   = active && cur_bit;
  assign frame_o = active && at_head && bit_first;
endmodule

// File: rtl/id_tone_tx_chk.sv
module id_tone_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_i,
  input logic active_i,
  input logic strobe_i,
  input logic tone_i,
  input logic bit_i,
  input logic frame_i
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !tone_i); // R2

  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i) && !$past(strobe_i)) |-> $stable(bit_i)); // R3

  AST_FRAME_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> !frame_i); // R4

  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && active_i && !bit_i) |=> !tone_i); // R6

  AST_BIT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> !tone_i); // R7

  AST_START_AT_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !$past(active_i)) |-> frame_i); // R8
endmodule

bind id_tone_tx id_tone_tx_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .active_i(active),
  .strobe_i(bit_stb),
  .tone_i  (tone_o),
  .bit_i   (bit_o),
  .frame_i (frame_o)
);

// File: tb/id_tone_tx_tb_top.sv
module id_tone_tx_tb_top;
  localparam int          ID_W    = 64;
  localparam logic [63:0] ID_WORD = 64'hC0DE_5A17_93E4_B60F;
  localparam int          BD      = 24;
  localparam int          BASE    = 1;
  localparam int          N_STG   = 1;
  localparam int          K_STG   = 2;
  localparam logic [7:0]  CODE    = 8'h5C;

  typedef struct {
    logic  tone;
    logic  bt;
    logic  frm;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       mode = 1'b0;
  logic       tvld = 1'b0;
  logic [7:0] tdata = 8'h00;
  logic       tone, bt, frm;

  int   n_run = 0;
  int   n_fail = 0;
  exp_t sb_q[$];

  // reference state: values held in the design registers during the current cycle
  int   m_c = 0;
  int   m_p = 0;
  logic m_tone = 1'b0;
  logic m_burst = 1'b0;

  always #2.5 clk = ~clk;

  id_tone_tx #(
    .ID_W(ID_W), .ID_WORD(ID_WORD), .BIT_DIV(BD), .BASE(BASE),
    .N_STG(N_STG), .K_STG(K_STG), .TRIG_W(8), .TRIG_CODE(CODE)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .trig_vld_i(tvld), .trig_data_i(tdata),
    .tone_o(tone), .bit_o(bt), .frame_o(frm)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: apply one cycle of stimulus, push expected outputs, advance model
  task automatic step(input logic e, input logic md, input logic tv, input logic [7:0] td,
                      input string tag);
    exp_t it;
    logic act, cb, on, hit;
    int   hp;
    @(posedge clk);
    #1;
    en = e; mode = md; tvld = tv; tdata = td;
    act = e || m_burst;
    cb  = ID_WORD[ID_W-1-m_p];
    it.tone = m_tone;
    it.bt   = act && cb;
    it.frm  = act && (m_p == 0) && (m_c == 0);
    it.tag  = tag;
    sb_q.push_back(it);
    hit = tv && (td == CODE);
    if (!act) begin
      m_c = 0; m_p = 0; m_tone = 1'b0;
      if (hit) m_burst = 1'b1;
    end else begin
      on = !md || cb;
      hp = (!md && cb) ? BASE + N_STG + K_STG : BASE + N_STG;
      if (m_c == BD - 1) begin
        m_tone = 1'b0;
        if (m_p == ID_W - 1) m_burst = 1'b0;
        m_c = 0;
        m_p = (m_p == ID_W - 1) ? 0 : m_p + 1;
      end else begin
        m_tone = on ? logic'(((m_c + 1) / hp) % 2) : 1'b0;
        m_c++;
      end
    end
  endtask

  task automatic run(input int n, input logic e, input logic md, input string tag);
    for (int i = 0; i < n; i++) step(e, md, 1'b0, 8'h00, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      check(it.tag, "tone_o",  tone, it.tone);
      check(it.tag, "bit_o",   bt,   it.bt);
      check(it.tag, "frame_o", frm,  it.frm);
    end
  end

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "tone_o",  tone, 1'b0);
    check("R1", "bit_o",   bt,   1'b0);
    check("R1", "frame_o", frm,  1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    run(10, 1'b0, 1'b0, "R2");
    // continuous two-tone transmission over more than two repetitions
    run(600,  1'b1, 1'b0, "R3");
    run(2600, 1'b1, 1'b0, "R4");
    run(200,  1'b1, 1'b0, "R5");
    run(200,  1'b1, 1'b0, "R7");
    run(30,   1'b0, 1'b0, "R2");
    // mid-bit stop then restart from the head
    run(100,  1'b1, 1'b0, "R8");
    run(13,   1'b0, 1'b0, "R2");
    run(60,   1'b1, 1'b0, "R8");
    run(20,   1'b0, 1'b1, "R2");
    // on-off keying over a full repetition
    run(1600, 1'b1, 1'b1, "R6");
    run(20,   1'b0, 1'b1, "R2");
    // wrong event code
    step(1'b0, 1'b0, 1'b1, 8'hA3, "R10");
    run(40, 1'b0, 1'b0, "R10");
    // matching event code: one repetition then idle
    step(1'b0, 1'b0, 1'b1, CODE, "R9");
    run(ID_W * BD + 60, 1'b0, 1'b0, "R9");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule